// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the two-wire serial slave front end of a 2K x 8 nonvolatile memory. It oversamples the SCL and SDA bus lines with the system clock, detects Start and Stop conditions, decodes the control byte and the word address, and answers on the bus through an open-drain pull-down enable. It provides byte write, page write, current-address read, random read and sequential read, and it owns the 11-bit address pointer.

Written bytes are handed out one per pulse to a neighbouring page-buffer block, together with their array address. A Stop that closes a write carrying data raises a commit pulse that tells that block to start its internal write cycle. While that block reports busy, the engine acknowledges nothing, so a master can poll for completion. Read data comes from the array through an address/data pair that is valid within one clock of an address change.

Top module: `eeprom_serial_slave`

## Requirements
- R1: A falling SDA while SCL is high is a Start, which at any point restarts reception of a control byte; a rising SDA while SCL is high is a Stop, which ends the transaction and returns the engine to idle.
- R2: The upper nibble of the control byte must be 1010 to be accepted; bits 3..1 become pointer bits 10..8 and bit 0 selects read (1) or write (0). Any other nibble gets no acknowledge, and the engine ignores the bus until the next Start or Stop.
- R3: For every accepted received byte, the engine pulls SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth; out of reset, and when idle, SDA is released.
- R4: While busy_i is high, no byte is acknowledged (a matching control byte included) and no write pulse is produced.
- R5: In a write, the byte after the control byte sets pointer bits 7..0; each following data byte produces a one-cycle wr_byte_o with the pointer as wr_addr_o and the byte as wr_data_o.
- R6: After each written byte only pointer bits 3..0 advance, wrapping from 15 to 0; bits 10..4 stay fixed.
- R7: A Stop after at least one data byte gives exactly one wr_commit_o pulse; a Stop or repeated Start after only the word address gives none, and the pointer keeps the address just loaded.
- R8: In a read the engine sends the byte at the pointer MSB first, changes SDA only after it has seen SCL fall, and keeps SDA steady while SCL is high; the pointer advances by one per byte sent.
- R9: During a read, a master acknowledge (SDA low on the ninth clock) brings the next byte; a missing acknowledge leaves SDA released until the next Start or Stop.
- R10: Read advancing runs through the whole array and wraps from 0x7FF to 0x000.
- R11: A read opened without a word address returns the byte following the last one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_addr_o | output | 11 | Array read address (the pointer) |
| rd_data_i | input | 8 | Array read data for rd_addr_o |
| wr_byte_o | output | 1 | One-cycle pulse: a data byte was accepted |
| wr_addr_o | output | 11 | Array address of the accepted byte |
| wr_data_o | output | 8 | Accepted data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start the write cycle |

## Verification
On every cycle the assertions check that SDA drive only changes once a falling SCL has been seen, that no acknowledge is driven in a transaction opened while the write cycle was busy, and that write and commit pulses are single-cycle, absent under busy, and follow only a Stop. Page wrapping of write addresses, pointer continuity between transactions, the wrap at the top of the array, rejection of a foreign control code and the difference between a closing Stop and a repeated Start need whole bus transactions, which only the bench scenarios drive and score.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MACKH,
    ST_IGNORE
  } slv_state_t;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDR,
    K_DATA
  } rx_kind_t;

endpackage

// File: rtl/eeprom_bus_sampler.sv
// Synchronizes the bus lines and derives edge and Start/Stop events (R1).
module eeprom_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic                   scl_q;
  logic                   sda_q;
  logic                   scl_s;
  logic                   sda_s;

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/eeprom_addr_ptr.sv
// Address pointer: block load, low-byte load, in-page and linear advance (R5, R6, R8, R10).
module eeprom_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int BLK_W  = 3,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_blk,
  input  logic [BLK_W-1:0]  blk,
  input  logic              ld_low,
  input  logic [ADDR_W-BLK_W-1:0] low,
  input  logic              inc_page,
  input  logic              inc_lin,
  output logic [ADDR_W-1:0] ptr_o
);

  localparam int LOW_W = ADDR_W - BLK_W;

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = ld_blk | ld_low | inc_page | inc_lin;
    if (ld_blk) begin
      ptr_d[ADDR_W-1:LOW_W] = blk;
    end
    if (ld_low) begin
      ptr_d[LOW_W-1:0] = low;
    end
    if (inc_page) begin
      ptr_d[PAGE_W-1:0] = ptr_q[PAGE_W-1:0] + 1'b1;
    end
    if (inc_lin) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/eeprom_proto_fsm.sv
// Byte-level protocol sequencer: receive, acknowledge, transmit, write hand-off.
module eeprom_proto_fsm
  import eeprom_slave_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          BLK_W     = 3,
  parameter logic [3:0]  CTRL_CODE = 4'b1010
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    start_det,
  input  logic                    stop_det,
  input  logic                    sda_lvl,
  input  logic                    busy_i,
  input  logic [BYTE_W-1:0]       rd_data_i,
  input  logic [ADDR_W-1:0]       ptr_i,
  output logic                    ld_blk_o,
  output logic [BLK_W-1:0]        blk_o,
  output logic                    ld_low_o,
  output logic [ADDR_W-BLK_W-1:0] low_o,
  output logic                    inc_page_o,
  output logic                    inc_lin_o,
  output logic                    sda_oe_o,
  output logic                    wr_byte_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [BYTE_W-1:0]       wr_data_o,
  output logic                    wr_commit_o
);

  localparam int LOW_W = ADDR_W - BLK_W;
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  slv_state_t         st_q,  st_d;
  rx_kind_t           kind_q, kind_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [BYTE_W-1:0]  sh_q,  sh_d;
  logic               rw_q,  rw_d;
  logic               wrote_q, wrote_d;
  logic               wrb_q, wrb_d;
  logic [ADDR_W-1:0]  wra_q, wra_d;
  logic [BYTE_W-1:0]  wrd_q, wrd_d;
  logic               cmt_q, cmt_d;
  logic [BYTE_W-1:0]  rx_byte;
  logic               byte_done;

  assign rx_byte   = {sh_q[BYTE_W-2:0], sda_lvl};
  assign byte_done = scl_rise & (bit_q == LAST_BIT);
  assign blk_o     = rx_byte[BLK_W:1];
  assign low_o     = rx_byte[LOW_W-1:0];

  // Next-state process
  always_comb begin
    st_d       = st_q;
    kind_d     = kind_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    rw_d       = rw_q;
    wrote_d    = wrote_q;
    wrb_d      = 1'b0;
    wra_d      = wra_q;
    wrd_d      = wrd_q;
    cmt_d      = 1'b0;
    ld_blk_o   = 1'b0;
    ld_low_o   = 1'b0;
    inc_page_o = 1'b0;
    inc_lin_o  = 1'b0;

    if (stop_det) begin
      // R1/R7: Stop closes; commit only when data was taken
      st_d    = ST_IDLE;
      cmt_d   = wrote_q;
      wrote_d = 1'b0;
    end else if (start_det) begin
      // R1/R7: (repeated) Start discards, never commits
      st_d    = ST_RX;
      kind_d  = K_CTRL;
      bit_d   = '0;
      wrote_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_IGNORE: begin
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = rx_byte;
            bit_d = bit_q + 1'b1;
          end
          if (byte_done) begin
            unique case (kind_q)
              K_CTRL: begin
                // R2/R4: code match and not busy
                if ((rx_byte[BYTE_W-1:BYTE_W-4] == CTRL_CODE) && !busy_i) begin
                  ld_blk_o = 1'b1;
                  rw_d     = rx_byte[0];
                  st_d     = ST_RXEND;
                end else begin
                  st_d = ST_IGNORE;
                end
              end
              K_ADDR: begin
                if (!busy_i) begin
                  ld_low_o = 1'b1;
                  st_d     = ST_RXEND;
                end else begin
                  st_d = ST_IGNORE;
                end
              end
              default: begin
                // R5/R6: hand the byte out, advance within the page
                if (!busy_i) begin
                  wrb_d      = 1'b1;
                  wra_d      = ptr_i;
                  wrd_d      = rx_byte;
                  inc_page_o = 1'b1;
                  wrote_d    = 1'b1;
                  st_d       = ST_RXEND;
                end else begin
                  st_d = ST_IGNORE;
                end
              end
            endcase
          end
        end
        ST_RXEND: begin
          if (scl_fall) begin
            st_d = ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if ((kind_q == K_CTRL) && rw_q) begin
              // R8: first read byte, pointer advances as it is taken
              sh_d      = rd_data_i;
              inc_lin_o = 1'b1;
              st_d      = ST_TX;
            end else begin
              kind_d = (kind_q == K_CTRL) ? K_ADDR : K_DATA;
              st_d   = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == LAST_BIT) begin
              st_d = ST_MACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
              bit_d = bit_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          // R9: master acknowledge decides continuation
          if (scl_rise) begin
            st_d = sda_lvl ? ST_IGNORE : ST_MACKH;
          end
        end
        ST_MACKH: begin
          if (scl_fall) begin
            sh_d      = rd_data_i;
            inc_lin_o = 1'b1;
            bit_d     = '0;
            st_d      = ST_TX;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_CTRL;
      bit_q   <= '0;
      sh_q    <= '1;
      rw_q    <= 1'b0;
      wrote_q <= 1'b0;
      wrb_q   <= 1'b0;
      wra_q   <= '0;
      wrd_q   <= '0;
      cmt_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      wrote_q <= wrote_d;
      wrb_q   <= wrb_d;
      cmt_q   <= cmt_d;
      if (wrb_d) begin
        wra_q <= wra_d;
        wrd_q <= wrd_d;
      end
    end
  end

  // R3/R8: drive low in the acknowledge slot or for a zero data bit
  assign sda_oe_o    = (st_q == ST_ACK) | ((st_q == ST_TX) & ~sh_q[BYTE_W-1]);
  assign wr_byte_o   = wrb_q;
  assign wr_addr_o   = wra_q;
  assign wr_data_o   = wrd_q;
  assign wr_commit_o = cmt_q;

endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
  import eeprom_slave_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         BLK_W       = 3,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] CTRL_CODE   = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_byte_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_commit_o
);

  localparam int LOW_W = ADDR_W - BLK_W;

  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              ld_blk;
  logic [BLK_W-1:0]  blk;
  logic              ld_low;
  logic [LOW_W-1:0]  low;
  logic              inc_page;
  logic              inc_lin;
  logic [ADDR_W-1:0] ptr;

  eeprom_bus_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  eeprom_addr_ptr #(
    .ADDR_W(ADDR_W),
    .BLK_W (BLK_W),
    .PAGE_W(PAGE_W)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_blk  (ld_blk),
    .blk     (blk),
    .ld_low  (ld_low),
    .low     (low),
    .inc_page(inc_page),
    .inc_lin (inc_lin),
    .ptr_o   (ptr)
  );

  eeprom_proto_fsm #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .CTRL_CODE(CTRL_CODE)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_lvl    (sda_lvl),
    .busy_i     (busy_i),
    .rd_data_i  (rd_data_i),
    .ptr_i      (ptr),
    .ld_blk_o   (ld_blk),
    .blk_o      (blk),
    .ld_low_o   (ld_low),
    .low_o      (low),
    .inc_page_o (inc_page),
    .inc_lin_o  (inc_lin),
    .sda_oe_o   (sda_oe_o),
    .wr_byte_o  (wr_byte_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_commit_o(wr_commit_o)
  );

  assign rd_addr_o = ptr;

endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_i,
  input logic sda_oe_o,
  input logic wr_byte_o,
  input logic wr_commit_o,
  input logic scl_rise,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det
);

  logic scl_low_q;
  logic busy_txn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_low_q  <= 1'b0;
      busy_txn_q <= 1'b0;
    end else begin
      if (scl_fall) begin
        scl_low_q <= 1'b1;
      end else if (scl_rise) begin
        scl_low_q <= 1'b0;
      end
      if (start_det) begin
        busy_txn_q <= busy_i;
      end else if (stop_det || !busy_i) begin
        busy_txn_q <= 1'b0;
      end
    end
  end

  // R8 / R3: drive changes only while the seen SCL level is low
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> scl_low_q);

  // R4: a transaction opened and held under busy is never acknowledged
  p_silent_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_txn_q |-> !sda_oe_o);

  // R4: no byte hand-off under busy
  p_no_wr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> !wr_byte_o);

  // R5: write pulse lasts one cycle
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_o |=> !wr_byte_o);

  // R7: commit only right after a Stop
  p_commit_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_det));

  // R7: commit lasts one cycle
  p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |=> !wr_commit_o);

endmodule

bind eeprom_serial_slave eeprom_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .sda_oe_o   (sda_oe_o),
  .wr_byte_o  (wr_byte_o),
  .wr_commit_o(wr_commit_o),
  .scl_rise   (scl_rise),
  .scl_fall   (scl_fall),
  .start_det  (start_det),
  .stop_det   (stop_det)
);

// File: tb/eeprom_serial_slave_tb.sv
module eeprom_serial_slave_tb;

  localparam int Q        = 8;
  localparam int BUSY_LEN = 900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_low = 1'b0;
  logic        busy = 1'b0;
  logic        sda_oe;
  logic [10:0] rd_addr;
  logic [7:0]  rd_data;
  logic        wr_byte;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_commit;
  logic        sda_line;

  logic [7:0]  mem [0:2047];
  logic [18:0] exp_wr_q [$];
  logic [18:0] pend_q [$];
  int          tests = 0;
  int          fails = 0;
  int          commits = 0;
  int          busy_cnt = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = ~(m_low | sda_oe);
  assign rd_data  = mem[rd_addr];

  eeprom_serial_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .busy_i     (busy),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_byte_o  (wr_byte),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .wr_commit_o(wr_commit)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw();
    scl = 1'b1;   qw();
    m_low = 1'b1; qw();
    scl = 1'b0;   qw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw();
    scl = 1'b1;   qw();
    m_low = 1'b0; qw(); qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qw();
      scl = 1'b1;    qw(); qw();
      scl = 1'b0;    qw();
    end
    m_low = 1'b0; qw();
    scl = 1'b1;   qw();
    ack = ~sda_line; qw();
    scl = 1'b0;   qw();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b, output bit steady);
    logic s1;
    logic s2;
    steady = 1'b1;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw();
      scl = 1'b1; qw();
      s1 = sda_line; qw();
      s2 = sda_line;
      if (s1 != s2) steady = 1'b0;
      b[i] = s1;
      scl = 1'b0;
    end
    qw();
    m_low = mack; qw();
    scl = 1'b1;   qw(); qw();
    scl = 1'b0;   qw();
    m_low = 1'b0;
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
    bit ack;
    send_byte(b, ack);
    chk(ack == exp_ack, tag, int'(ack), int'(exp_ack));
  endtask

  task automatic read_chk(input bit mack, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    bit steady;
    recv_byte(mack, b, steady);
    chk(b == exp, tag, int'(b), int'(exp));
    chk(steady, "R8 SDA steady while SCL high", int'(steady), 1);
  endtask

  task automatic push_wr(input logic [10:0] a, input logic [7:0] d);
    exp_wr_q.push_back({a, d});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: scores byte hand-offs and models the page buffer
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_byte) begin
        if (exp_wr_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R5 unexpected write actual=0x%0h expected=none", {wr_addr, wr_data});
        end else begin
          logic [18:0] e;
          e = exp_wr_q.pop_front();
          chk({wr_addr, wr_data} == e, "R5/R6 write address and data",
              int'({wr_addr, wr_data}), int'(e));
        end
        pend_q.push_back({wr_addr, wr_data});
      end
      if (wr_commit) begin
        commits++;
        while (pend_q.size() > 0) begin
          logic [18:0] p;
          p = pend_q.pop_front();
          mem[p[18:8]] = p[7:0];
        end
        busy_cnt = BUSY_LEN;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
      end
      busy = (busy_cnt != 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R3 reset releases SDA", int'(sda_oe), 0);
    chk(wr_byte == 1'b0 && wr_commit == 1'b0, "R5 reset no write pulse",
        int'({wr_byte, wr_commit}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Byte write to 0x235
    bus_start();
    send_chk(8'hA4, 1'b1, "R2 write control accepted");
    send_chk(8'h35, 1'b1, "R3 word address acknowledged");
    push_wr(11'h235, 8'h5A);
    send_chk(8'h5A, 1'b1, "R5 data byte acknowledged");
    bus_stop();
    chk(commits == 1, "R7 commit after Stop with data", commits, 1);

    // Poll while busy, then after
    bus_start();
    send_chk(8'hA4, 1'b0, "R4 no acknowledge while busy");
    bus_stop();
    wait_idle();
    bus_start();
    send_chk(8'hA4, 1'b1, "R4 acknowledge once idle");
    bus_stop();
    chk(commits == 1, "R7 no commit for control-only write", commits, 1);

    // Current-address read: follows last written byte
    bus_start();
    send_chk(8'hA5, 1'b1, "R2 read control accepted");
    read_chk(1'b0, init_val(11'h236), "R11 current address read");
    bus_stop();

    // Random read with repeated Start, sequential across array top
    bus_start();
    send_chk(8'hAE, 1'b1, "R2 block 7 write control");
    send_chk(8'hFE, 1'b1, "R7 word address for random read");
    bus_start();
    send_chk(8'hAF, 1'b1, "R1 repeated Start restarts control");
    read_chk(1'b1, init_val(11'h7FE), "R8 random read byte");
    read_chk(1'b1, init_val(11'h7FF), "R10 last address");
    read_chk(1'b0, init_val(0), "R10 wrap to zero");
    // Engine must stay released after master no-acknowledge
    read_chk(1'b0, 8'hFF, "R9 released after no acknowledge");
    bus_stop();
    chk(commits == 1 && busy == 1'b0, "R7 repeated Start gives no commit", commits, 1);

    // Page write crossing page end
    bus_start();
    send_chk(8'hA2, 1'b1, "R2 block 1 write control");
    send_chk(8'h1E, 1'b1, "R5 word address 0x1E");
    push_wr(11'h11E, 8'h11);
    send_chk(8'h11, 1'b1, "R6 page byte 0");
    push_wr(11'h11F, 8'h22);
    send_chk(8'h22, 1'b1, "R6 page byte 1");
    push_wr(11'h110, 8'h33);
    send_chk(8'h33, 1'b1, "R6 page byte 2 wraps");
    bus_stop();
    chk(commits == 2, "R7 page commit", commits, 2);
    wait_idle();

    // Read back: linear after wrapped location
    bus_start();
    send_chk(8'hA2, 1'b1, "R2 block 1 write control again");
    send_chk(8'h10, 1'b1, "R5 word address 0x10");
    bus_start();
    send_chk(8'hA3, 1'b1, "R2 block 1 read control");
    read_chk(1'b1, 8'h33, "R6 wrapped byte stored at page start");
    read_chk(1'b0, init_val(11'h111), "R9 acknowledge gives next linear byte");
    bus_stop();

    bus_start();
    send_chk(8'hA4, 1'b1, "R2 block 2 write control");
    send_chk(8'h35, 1'b1, "R5 word address 0x35");
    bus_start();
    send_chk(8'hA5, 1'b1, "R2 block 2 read control");
    read_chk(1'b0, 8'h5A, "R5 byte write stored");
    bus_stop();

    // Foreign control code is ignored
    bus_start();
    send_chk(8'hB0, 1'b0, "R2 foreign code not acknowledged");
    send_chk(8'h00, 1'b0, "R2 bus ignored after foreign code");
    bus_start();
    send_chk(8'hA0, 1'b1, "R1 Start after ignore accepted");
    send_chk(8'h40, 1'b1, "R7 address only");
    bus_stop();
    chk(commits == 2, "R7 Stop after address only gives no commit", commits, 2);
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R3 idle releases SDA", int'(sda_oe), 0);
    chk(exp_wr_q.size() == 0, "R5 all expected writes seen", exp_wr_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule